// File: doc/BRIEF.md
# Upstream Bus Reset Detector

This block watches the upstream differential pair of a USB function for a long single-ended-zero (SE0) condition, both lines low together, and turns such a condition into a bus reset event. It samples the two lines on the 12 MHz system clock and counts how many consecutive clocks the SE0 lasts. Any sample that is not SE0 clears the count before it reaches the threshold. Once the count reaches a fixed threshold inside the 12 to 16 microsecond acceptance window, the block does four things:

- it sets a sticky status flag that firmware reads and clears;
- it pulses one strobe that clears the device address registers;
- it pulses a second strobe that clears the hub connect status register;
- if a power-on startup delay is still running, it pulses a request to abort that delay.

The reset interrupt request is held back until the lines leave SE0, and it is then issued as a one-clock pulse. The line transceivers, any deglitch filtering and the registers being cleared sit outside the block. Only the strobes come out of it.

Top module: `usb_busreset_detect`

## Requirements
- R1: SE0 means dp=0 and dm=0 in the same sample. A pair with dp=0/dm=1, dp=1/dm=0 or dp=1/dm=1 never counts toward a reset, however long it is held.
- R2: An SE0 held for at least SE0_CYCLES (default 168) consecutive samples is recognised as a bus reset. The clear strobes rise SE0_CYCLES+1 clocks after the first clock edge that samples SE0.
- R3: An SE0 held for fewer than SE0_CYCLES consecutive samples is never recognised. One non-SE0 sample restarts the count from zero, so two short runs do not add up.
- R4: Each recognised reset gives exactly one single-cycle pulse on clr_addr_stb and exactly one on clr_hub_stb, both in the same cycle. An SE0 that continues past recognition gives no further pulse.
- R5: rst_status goes to 1 in the cycle the clear strobes are high. It then stays 1 while no clear is written.
- R6: A firmware write with fw_wr=1 and fw_wdata=0 clears rst_status one clock later. A write of 1 has no effect. If a write of 0 lands in the same cycle as recognition, the status is still set.
- R7: rst_irq is a single-cycle pulse, and it is issued only after a recognised reset. It rises two clocks after the first clock edge that samples the lines out of SE0, and never while SE0 is still being sampled.
- R8: por_abort pulses in the same cycle as the clear strobes, and only when por_busy is 1 at recognition.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dp | input | 1 | Upstream D+ line level |
| dm | input | 1 | Upstream D- line level |
| por_busy | input | 1 | Power-on startup delay is running |
| fw_wr | input | 1 | Firmware write to the reset status bit |
| fw_wdata | input | 1 | Value written by firmware |
| rst_status | output | 1 | Sticky bus reset status flag |
| clr_addr_stb | output | 1 | Clear pulse for device address registers |
| clr_hub_stb | output | 1 | Clear pulse for hub connect status register |
| por_abort | output | 1 | Abort pulse for the startup delay |
| rst_irq | output | 1 | Bus reset interrupt pulse on SE0 release |

## Verification
The bench sweeps the SE0 length over every value from 0 to 200 clocks. This covers the edge at SE0_CYCLES-1 versus SE0_CYCLES: a counter that is one off would either miss a reset at exactly the threshold or accept one a clock early. It times both the strobe and the interrupt cycle by cycle. A design that fired the interrupt at detection, or twice over a long SE0, shows a wrong pulse count or a wrong cycle. Further cases cover:

- line pairs that are not SE0, and split SE0 runs, which a counter that fails to restart would wrongly accept;
- a firmware clear that collides with recognition;
- the abort pulse, checked with the startup delay both idle and running.

// File: rtl/usb_busreset_pkg.sv
package usb_busreset_pkg;
   // Control state of the reset event sequencer
   typedef enum logic [0:0] {
      ST_IDLE  = 1'b0,
      ST_INRST = 1'b1
   } rst_state_e;

   // Bundle of one-cycle event outputs
   typedef struct packed {
      logic clr_addr;
      logic clr_hub;
      logic abort;
      logic irq;
   } rst_events_t;
endpackage

// File: rtl/se0_sampler.sv
module se0_sampler #(
   parameter bit SAMPLE_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dp,
   input  logic dm,
   output logic se0
);
   logic se0_raw;
   assign se0_raw = ~dp & ~dm;

   generate
      if (SAMPLE_REG) begin : g_reg
         logic se0_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) se0_q <= 1'b0;
            else        se0_q <= se0_raw;
         end
         assign se0 = se0_q;
      end else begin : g_comb
         assign se0 = se0_raw;
      end
   endgenerate
endmodule

// File: rtl/se0_timer.sv
module se0_timer #(
   parameter int unsigned SE0_CYCLES = 168
) (
   input  logic clk,
   input  logic rst_n,
   input  logic se0,
   output logic detect
);
   localparam int unsigned CW = $clog2(SE0_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(SE0_CYCLES - 1);
   localparam logic [CW-1:0] SAT  = CW'(SE0_CYCLES);

   logic [CW-1:0] cnt_q;

   // Count consecutive SE0 samples, restart on any other sample, hold at SAT
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!se0)       cnt_q <= '0;
      else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
   end

   // The threshold sample itself is the moment of recognition
   assign detect = se0 && (cnt_q == LAST);

   assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= SAT);
   assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !se0 |=> (cnt_q == '0));
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
   import usb_busreset_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        se0,
   input  logic        detect,
   input  logic        por_busy,
   output rst_events_t ev
);
   rst_state_e  st_q;
   rst_events_t ev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         ev_q <= '0;
      end else begin
         ev_q.clr_addr <= detect;
         ev_q.clr_hub  <= detect;
         ev_q.abort    <= detect & por_busy;
         ev_q.irq      <= (st_q == ST_INRST) & ~se0;
         case (st_q)
            ST_IDLE:  if (detect) st_q <= ST_INRST;
            ST_INRST: if (!se0)   st_q <= ST_IDLE;
            default:              st_q <= ST_IDLE;
         endcase
      end
   end

   assign ev = ev_q;

   assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_q.clr_addr |=> !ev_q.clr_addr);
   assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_q.irq |=> !ev_q.irq);
   assert_irq_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_q.irq |-> !$past(se0));
   assert_abort_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_q.abort |-> ev_q.clr_addr);
endmodule

// File: rtl/status_flag.sv
module status_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic fw_wr,
   input  logic fw_wdata,
   output logic status
);
   logic st_q;
   logic clr_req;
   assign clr_req = fw_wr & ~fw_wdata;

   // Hardware set takes priority over a firmware clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       st_q <= 1'b0;
      else if (set_ev)  st_q <= 1'b1;
      else if (clr_req) st_q <= 1'b0;
   end
   assign status = st_q;

   assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q && !clr_req) |=> st_q);
   assert_status_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !set_ev) |=> !st_q);
endmodule

// File: rtl/usb_busreset_detect.sv
module usb_busreset_detect
   import usb_busreset_pkg::*;
#(
   parameter int unsigned SE0_CYCLES = 168,
   parameter int unsigned WIN_MIN    = 144,
   parameter int unsigned WIN_MAX    = 192,
   parameter bit          SAMPLE_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dp,
   input  logic dm,
   input  logic por_busy,
   input  logic fw_wr,
   input  logic fw_wdata,
   output logic rst_status,
   output logic clr_addr_stb,
   output logic clr_hub_stb,
   output logic por_abort,
   output logic rst_irq
);
   initial begin
      assert (SE0_CYCLES >= 2)
         else $error("SE0_CYCLES must be at least 2");
      assert (SE0_CYCLES >= WIN_MIN && SE0_CYCLES < WIN_MAX)
         else $error("SE0_CYCLES outside acceptance window");
   end

   logic        se0;
   logic        detect;
   rst_events_t ev;

   se0_sampler #(.SAMPLE_REG(SAMPLE_REG)) u_samp (
      .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm), .se0(se0));

   se0_timer #(.SE0_CYCLES(SE0_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .se0(se0), .detect(detect));

   reset_sequencer u_seq (
      .clk(clk), .rst_n(rst_n), .se0(se0), .detect(detect),
      .por_busy(por_busy), .ev(ev));

   status_flag u_stat (
      .clk(clk), .rst_n(rst_n), .set_ev(detect), .fw_wr(fw_wr),
      .fw_wdata(fw_wdata), .status(rst_status));

   assign clr_addr_stb = ev.clr_addr;
   assign clr_hub_stb  = ev.clr_hub;
   assign por_abort    = ev.abort;
   assign rst_irq      = ev.irq;

   assert_strobe_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_addr_stb == clr_hub_stb);
   assert_status_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_addr_stb |-> rst_status);
endmodule

// File: tb/usb_busreset_detect_test.sv
`timescale 1ns/1ps
module usb_busreset_detect_test;
   localparam int T = 168;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dp = 1'b1, dm = 1'b0, por_busy = 1'b0, fw_wr = 1'b0, fw_wdata = 1'b0;
   logic rst_status, clr_addr_stb, clr_hub_stb, por_abort, rst_irq;

   int total = 0, bad = 0;
   int cyc = 0;
   int n_addr, n_hub, n_abort, n_irq, c_stb, c_irq;

   always #2.5 clk = ~clk;

   usb_busreset_detect uut (
      .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm), .por_busy(por_busy),
      .fw_wr(fw_wr), .fw_wdata(fw_wdata), .rst_status(rst_status),
      .clr_addr_stb(clr_addr_stb), .clr_hub_stb(clr_hub_stb),
      .por_abort(por_abort), .rst_irq(rst_irq));

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (clr_addr_stb) begin n_addr++; c_stb = cyc; end
      if (clr_hub_stb)  n_hub++;
      if (por_abort)    n_abort++;
      if (rst_irq)      begin n_irq++; c_irq = cyc; end
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_counts();
      n_addr = 0; n_hub = 0; n_abort = 0; n_irq = 0; c_stb = -1; c_irq = -1;
   endtask

   // Drive line pair (a,b) for n samples, then return to idle J and settle
   task automatic hold_pair(input logic a, input logic b, input int n,
                            input logic por, input int clr_at);
      @(negedge clk);
      fw_wr = 1'b0; por_busy = por; dp = a; dm = b; cyc = 0;
      for (int i = 1; i <= n; i++) begin
         @(negedge clk);
         fw_wr = (i == clr_at); fw_wdata = 1'b0;
      end
      dp = 1'b1; dm = 1'b0; fw_wr = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic fw_clear();
      @(negedge clk); fw_wr = 1'b1; fw_wdata = 1'b0;
      @(negedge clk); fw_wr = 1'b0;
   endtask

   initial begin
      #200000000;
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      clear_counts();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 status", rst_status, 0);
      chk("R9 addr", clr_addr_stb, 0);
      chk("R9 hub", clr_hub_stb, 0);
      chk("R9 abort", por_abort, 0);
      chk("R9 irq", rst_irq, 0);

      // R2 R3 R4 R7 R8: sweep SE0 length
      for (int n = 0; n <= 200; n++) begin
         logic por;
         int rec;
         por = n[0];
         rec = (n >= T) ? 1 : 0;
         fw_clear();
         clear_counts();
         hold_pair(1'b0, 1'b0, n, por, -1);
         if (rec == 1) chk("R2 recognised", rst_status, 1);
         else          chk("R3 not recognised", rst_status, 0);
         chk("R4 addr strobes", n_addr, rec);
         chk("R4 hub strobes", n_hub, rec);
         chk("R7 irq count", n_irq, rec);
         chk("R8 abort count", n_abort, rec & por);
         if (rec == 1) begin
            chk("R2 strobe cycle", c_stb, T + 1);
            chk("R7 irq cycle", c_irq, n + 2);
         end
      end

      // R1: non-SE0 pairs held long
      fw_clear(); clear_counts();
      hold_pair(1'b0, 1'b1, 200, 1'b1, -1);
      hold_pair(1'b1, 1'b1, 200, 1'b1, -1);
      hold_pair(1'b1, 1'b0, 200, 1'b1, -1);
      chk("R1 no strobe", n_addr, 0);
      chk("R1 no irq", n_irq, 0);
      chk("R1 status", rst_status, 0);

      // R3: split SE0 runs do not add up
      clear_counts();
      hold_pair(1'b0, 1'b0, T - 1, 1'b0, -1);
      hold_pair(1'b0, 1'b0, T - 1, 1'b0, -1);
      chk("R3 split runs strobe", n_addr, 0);
      chk("R3 split runs status", rst_status, 0);

      // R6: write 1 no effect, write 0 clears
      clear_counts();
      hold_pair(1'b0, 1'b0, 180, 1'b0, -1);
      chk("R5 status set", rst_status, 1);
      @(negedge clk); fw_wr = 1'b1; fw_wdata = 1'b1;
      @(negedge clk); fw_wr = 1'b0;
      chk("R6 write 1 ignored", rst_status, 1);
      repeat (20) @(negedge clk);
      chk("R5 status held", rst_status, 1);
      @(negedge clk); fw_wr = 1'b1; fw_wdata = 1'b0;
      @(negedge clk); fw_wr = 1'b0;
      chk("R6 write 0 clears", rst_status, 0);

      // R6: clear colliding with recognition; set wins
      hold_pair(1'b0, 1'b0, 180, 1'b0, T);
      chk("R6 set beats clear", rst_status, 1);
      // clear after recognition during SE0
      fw_clear();
      hold_pair(1'b0, 1'b0, 180, 1'b0, T + 5);
      chk("R6 clear after set", rst_status, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule